// File: doc/BRIEF.md
# Multi-Bank Chip-Select Decoder

This block decides, for every external bus request, which of several programmable memory banks the access belongs to. Each bank is described by two software-written words. A base word holds the bank's start address, an address-type value, a port-size code, a write-protect flag and an enable flag. An option word holds a per-bit address mask and a per-bit address-type mask. A request matches a bank when the enabled bank's base address and type agree with the request in every masked-in position. When several banks match, the lowest-numbered one wins.

The winning bank drives a one-hot chip select and reports its port size, and the block raises a one-cycle internal acknowledge. A write whose winning bank is write-protected is handled as if nothing matched: no select and no acknowledge are driven, so the cycle is left for external logic to terminate. The block also records the violation in a sticky per-bank flag that software clears by writing ones.

Top module: `cs_decoder`

## Requirements
- R1: After reset, chip selects, port size and acknowledge are 0, the violation status reads 0, and every base and option word reads 0, so no bank responds until software enables one.
- R2: Register offsets are: base word of bank i at 2*i, option word of bank i at 2*i+1, violation status at 2*NUM_BANKS. Base word fields are [31:12] base address, [6:4] type, [3:2] port size, [1] write protect, [0] enable. Option word fields are [31:12] address mask and [6:4] type mask. All other bits read as 0.
- R3: A bank matches when addr[31:12] equals its base address in every bit where the address mask is 1. Bits where the mask is 0 are ignored.
- R4: The request type is compared with the bank's type only where the type mask is 1. A type mask of 0 accepts any type.
- R5: When more than one bank matches, only the lowest-numbered matching bank is selected.
- R6: Chip select and port size appear one clock after the strobe is sampled high. They are re-evaluated every clock while the strobe stays high and clear one clock after it drops. Port-size codes are 01 = 8-bit, 10 = 16-bit and 00 = 32-bit. The port size reads 0 when no select is driven.
- R7: The acknowledge is high for exactly one clock, in the first clock a select is driven for a request. It never rises for a miss or a violation.
- R8: A write (rnw = 0) whose selected bank has write protect set drives no select and no acknowledge, and it sets that bank's status bit. A read of the same bank is served normally. Protection on a bank that loses the priority decision has no effect.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A violation in the same clock as a clear leaves the bit set.
- R10: A bank with its enable bit at 0 never matches, whatever its other fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Bus request strobe, held for the request |
| addr_i | input | 32 | Request address |
| atype_i | input | 3 | Request address type |
| rnw_i | input | 1 | 1 = read, 0 = write |
| reg_wr_i | input | 1 | Register write enable |
| reg_addr_i | input | RA_W (4) | Register offset for both write and read |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| cs_o | output | NUM_BANKS | One-hot chip selects |
| ps_o | output | 2 | Port size of the selected bank |
| ack_o | output | 1 | Internal acknowledge pulse |
| wp_status_o | output | NUM_BANKS | Sticky write-protect violation flags |

## Verification
The bench builds the block with its default of four banks, which gives a 4-bit register offset and puts the status word at offset 8. Four banks are enough to set up two overlapping regions with opposite protection, a type-checked region and a disabled region at the same time. With these regions, priority between overlapping banks, the loser's protection being ignored, type masking and the enable flag can all be checked against one programmed map. The request timing, the acknowledge pulse and a clear landing in the same clock as a new violation are then checked as directed cases.

// File: rtl/cs_pkg.sv
// Shared widths, field positions and register types of the chip-select decoder.
// Assumes a 32-bit register word that is as wide as the bus address.
package cs_pkg;
    localparam int ADDR_W    = 32;
    localparam int REG_W     = ADDR_W;
    localparam int BLK_LSB   = 12;
    localparam int CMP_W     = ADDR_W - BLK_LSB;
    localparam int TYPE_W    = 3;
    localparam int PS_W      = 2;
    localparam int F_VALID   = 0;
    localparam int F_WP      = 1;
    localparam int F_PS_LO   = 2;
    localparam int F_TYPE_LO = 4;

    typedef enum logic [PS_W-1:0] {
        PS_32  = 2'b00,
        PS_8   = 2'b01,
        PS_16  = 2'b10,
        PS_RSV = 2'b11
    } port_size_e;

    typedef struct packed {
        logic [CMP_W-1:0]  base;
        logic [TYPE_W-1:0] atype;
        port_size_e        ps;
        logic              wp;
        logic              valid;
    } base_reg_t;

    typedef struct packed {
        logic [CMP_W-1:0]  amask;
        logic [TYPE_W-1:0] tmask;
    } opt_reg_t;

    // Lay a base register out as a bus word.
    function automatic logic [REG_W-1:0] base_to_word(base_reg_t b);
        logic [REG_W-1:0] w;
        w = '0;
        w[ADDR_W-1:BLK_LSB]             = b.base;
        w[F_TYPE_LO+TYPE_W-1:F_TYPE_LO] = b.atype;
        w[F_PS_LO+PS_W-1:F_PS_LO]       = b.ps;
        w[F_WP]                         = b.wp;
        w[F_VALID]                      = b.valid;
        return w;
    endfunction

    // Extract a base register from a bus word.
    function automatic base_reg_t word_to_base(logic [REG_W-1:0] w);
        base_reg_t b;
        b.base  = w[ADDR_W-1:BLK_LSB];
        b.atype = w[F_TYPE_LO+TYPE_W-1:F_TYPE_LO];
        b.ps    = port_size_e'(w[F_PS_LO+PS_W-1:F_PS_LO]);
        b.wp    = w[F_WP];
        b.valid = w[F_VALID];
        return b;
    endfunction

    // Lay an option register out as a bus word.
    function automatic logic [REG_W-1:0] opt_to_word(opt_reg_t o);
        logic [REG_W-1:0] w;
        w = '0;
        w[ADDR_W-1:BLK_LSB]             = o.amask;
        w[F_TYPE_LO+TYPE_W-1:F_TYPE_LO] = o.tmask;
        return w;
    endfunction

    // Extract an option register from a bus word.
    function automatic opt_reg_t word_to_opt(logic [REG_W-1:0] w);
        opt_reg_t o;
        o.amask = w[ADDR_W-1:BLK_LSB];
        o.tmask = w[F_TYPE_LO+TYPE_W-1:F_TYPE_LO];
        return o;
    endfunction
endpackage

// File: rtl/cs_regfile.sv
// Bank configuration registers and sticky violation status.
// Assumes a single offset shared by write and read. Read data is combinational.
// Status bits are set by viol_set and cleared by writing ones; a set wins over a clear.
module cs_regfile
    import cs_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int RA_W      = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [RA_W-1:0]      addr,
    input  logic [REG_W-1:0]     wr_data,
    input  logic [NUM_BANKS-1:0] viol_set,
    output base_reg_t            base_q [NUM_BANKS],
    output opt_reg_t             opt_q  [NUM_BANKS],
    output logic [NUM_BANKS-1:0] status_q,
    output logic [REG_W-1:0]     rd_data
);
    localparam logic [RA_W-1:0] STAT_OFS = RA_W'(2 * NUM_BANKS);

    logic [NUM_BANKS-1:0] clr_mask;

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank_regs
        localparam logic [RA_W-1:0] BASE_OFS = RA_W'(2 * i);
        localparam logic [RA_W-1:0] OPT_OFS  = RA_W'(2 * i + 1);

        // Base word of this bank: reset disables the bank.
        always_ff @(posedge clk) begin
            if (!rst_n)
                base_q[i] <= '0;
            else if (wr_en && addr == BASE_OFS)
                base_q[i] <= word_to_base(wr_data);
        end

        // Option word of this bank.
        always_ff @(posedge clk) begin
            if (!rst_n)
                opt_q[i] <= '0;
            else if (wr_en && addr == OPT_OFS)
                opt_q[i] <= word_to_opt(wr_data);
        end
    end

    // Write-one-to-clear mask for the status word.
    always_comb begin
        clr_mask = '0;
        if (wr_en && addr == STAT_OFS)
            clr_mask = wr_data[NUM_BANKS-1:0];
    end

    // Sticky violation flags: a new violation outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else
            status_q <= (status_q & ~clr_mask) | viol_set;
    end

    // Read mux over all words; unknown offsets read 0.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (addr == RA_W'(2 * i))
                rd_data = base_to_word(base_q[i]);
            if (addr == RA_W'(2 * i + 1))
                rd_data = opt_to_word(opt_q[i]);
        end
        if (addr == STAT_OFS)
            rd_data = REG_W'(status_q);
    end

    // R9
    // sticky_set_chk
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_set != '0) |=> ((status_q & $past(viol_set)) == $past(viol_set)));

    // R9
    // clear_no_set_chk
    clear_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask != '0 && viol_set == '0) |=> ((status_q & $past(clr_mask)) == '0));
endmodule

// File: rtl/cs_bank_match.sv
// Address and type comparison for one bank.
// Assumes the caller passes only the compared upper address bits.
module cs_bank_match
    import cs_pkg::*;
(
    input  base_reg_t          cfg,
    input  opt_reg_t           opt,
    input  logic [CMP_W-1:0]   addr_hi,
    input  logic [TYPE_W-1:0]  atype,
    output logic               hit
);
    logic addr_ok;
    logic type_ok;

    // Masked comparisons; an all-zero mask accepts anything.
    always_comb begin
        addr_ok = ((addr_hi ^ cfg.base) & opt.amask) == '0;
        type_ok = ((atype ^ cfg.atype) & opt.tmask) == '0;
        hit     = cfg.valid && addr_ok && type_ok;
    end

    // R10
    // hit_needs_valid_chk
    always_comb begin
        hit_needs_valid_chk: assert (!hit || cfg.valid);
    end
endmodule

// File: rtl/cs_prio_sel.sv
// Fixed-priority picker: the lowest set bit of the match vector wins.
// Assumes NUM_BANKS of at least 2. The index is only meaningful when grant is non-zero.
module cs_prio_sel #(
    parameter int NUM_BANKS = 4,
    parameter int IDX_W     = 2
) (
    input  logic [NUM_BANKS-1:0] match,
    output logic [NUM_BANKS-1:0] grant,
    output logic [IDX_W-1:0]     idx
);
    // Scan from the top so the lowest match is written last.
    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (match[i]) begin
                grant = '0;
                grant[i] = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/cs_decoder.sv
// Top of the multi-bank chip-select decoder.
// It matches each request against every bank, keeps the lowest match and blocks
// protected writes. Selects, port size and acknowledge are registered.
// Assumes address, type and direction stay stable while req_i is high.
module cs_decoder
    import cs_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int RA_W     = $clog2(2 * NUM_BANKS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [TYPE_W-1:0]    atype_i,
    input  logic                 rnw_i,
    input  logic                 reg_wr_i,
    input  logic [RA_W-1:0]      reg_addr_i,
    input  logic [REG_W-1:0]     reg_wdata_i,
    output logic [REG_W-1:0]     reg_rdata_o,
    output logic [NUM_BANKS-1:0] cs_o,
    output logic [PS_W-1:0]      ps_o,
    output logic                 ack_o,
    output logic [NUM_BANKS-1:0] wp_status_o
);
    localparam int IDX_W = $clog2(NUM_BANKS);

    base_reg_t            base_q [NUM_BANKS];
    opt_reg_t             opt_q  [NUM_BANKS];
    logic [NUM_BANKS-1:0] hit_vec;
    logic [NUM_BANKS-1:0] grant;
    logic [NUM_BANKS-1:0] wp_vec;
    logic [NUM_BANKS-1:0] viol_set;
    logic [IDX_W-1:0]     win_idx;
    logic                 any_hit;
    logic                 protect;
    logic                 accept;
    logic                 start;
    logic                 req_q;
    logic [NUM_BANKS-1:0] cs_q;
    logic [PS_W-1:0]      ps_q;
    logic                 ack_q;
    wire                  unused_addr_lsb = ^addr_i[BLK_LSB-1:0];

    cs_regfile #(
        .NUM_BANKS (NUM_BANKS),
        .RA_W      (RA_W)
    ) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_i),
        .addr     (reg_addr_i),
        .wr_data  (reg_wdata_i),
        .viol_set (viol_set),
        .base_q   (base_q),
        .opt_q    (opt_q),
        .status_q (wp_status_o),
        .rd_data  (reg_rdata_o)
    );

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_match
        cs_bank_match i_match (
            .cfg     (base_q[i]),
            .opt     (opt_q[i]),
            .addr_hi (addr_i[ADDR_W-1:BLK_LSB]),
            .atype   (atype_i),
            .hit     (hit_vec[i])
        );
        assign wp_vec[i] = base_q[i].wp;
    end

    cs_prio_sel #(
        .NUM_BANKS (NUM_BANKS),
        .IDX_W     (IDX_W)
    ) i_prio (
        .match (hit_vec),
        .grant (grant),
        .idx   (win_idx)
    );

    // Decide between serving, refusing and ignoring the request.
    always_comb begin
        any_hit  = |grant;
        protect  = any_hit && base_q[win_idx].wp && !rnw_i;
        accept   = req_i && any_hit && !protect;
        start    = req_i && !req_q;
        viol_set = (start && protect) ? grant : '0;
    end

    // Registered outputs, re-evaluated every cycle the strobe is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            cs_q  <= '0;
            ps_q  <= '0;
            ack_q <= 1'b0;
        end else begin
            req_q <= req_i;
            cs_q  <= accept ? grant : '0;
            ps_q  <= accept ? base_q[win_idx].ps : '0;
            ack_q <= accept && start;
        end
    end

    assign cs_o  = cs_q;
    assign ps_o  = ps_q;
    assign ack_o = ack_q;

    // R5
    // cs_onehot_chk
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_o));

    // R5
    // lowest_wins_chk
    lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> (((grant - 1'b1) & hit_vec) == '0 && (grant & hit_vec) != '0));

    // R6
    // cs_needs_req_chk
    cs_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_o != '0) |-> $past(req_i));

    // R7
    // ack_pulse_chk
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    // R7
    // ack_with_cs_chk
    ack_with_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (cs_o != '0));

    // R8
    // wp_no_cs_chk
    wp_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_o != '0 && !$past(rnw_i)) |-> ((cs_o & $past(wp_vec)) == '0));
endmodule

// File: tb/test_cs_decoder.sv
// Self-checking bench: programs a bank map, walks a vector table, then runs directed cases.
module test_cs_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int NB         = 4;
    localparam int RA_W       = 4;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic [23:0] tag;
        logic [31:0] addr;
        logic [2:0]  atype;
        logic        rnw;
        logic [3:0]  cs;
        logic [1:0]  ps;
        logic        ack;
        logic [3:0]  viol;
    } vec_t;

    // Bank map: 0 = 0x0000xxxx 8-bit; 1 = 0x00xxxxxx 16-bit protected;
    // 2 = 0x1xxxxxxx 32-bit type 5; 3 = 0x3xxxxxxx disabled.
    localparam vec_t VECS [9] = '{
        '{"R5 ", 32'h0000_1234, 3'd0, 1'b1, 4'b0001, 2'b01, 1'b1, 4'b0000},
        '{"R8 ", 32'h0000_1234, 3'd0, 1'b0, 4'b0001, 2'b01, 1'b1, 4'b0000},
        '{"R3 ", 32'h0050_0000, 3'd2, 1'b1, 4'b0010, 2'b10, 1'b1, 4'b0000},
        '{"R8 ", 32'h0050_0000, 3'd2, 1'b0, 4'b0000, 2'b00, 1'b0, 4'b0010},
        '{"R4 ", 32'h1234_5678, 3'd5, 1'b0, 4'b0100, 2'b00, 1'b1, 4'b0000},
        '{"R4 ", 32'h1234_5678, 3'd4, 1'b1, 4'b0000, 2'b00, 1'b0, 4'b0000},
        '{"R10", 32'h3000_0000, 3'd0, 1'b1, 4'b0000, 2'b00, 1'b0, 4'b0000},
        '{"R3 ", 32'h4000_0000, 3'd0, 1'b1, 4'b0000, 2'b00, 1'b0, 4'b0000},
        '{"R3 ", 32'h0000_F000, 3'd7, 1'b1, 4'b0001, 2'b01, 1'b1, 4'b0000}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req = 1'b0;
    logic [31:0]     addr = '0;
    logic [2:0]      atype = '0;
    logic            rnw = 1'b1;
    logic            reg_wr = 1'b0;
    logic [RA_W-1:0] reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NB-1:0]   cs;
    logic [1:0]      ps;
    logic            ack;
    logic [NB-1:0]   wp_status;

    int n_checks = 0;
    int n_fails  = 0;
    logic [3:0] exp_status = '0;

    cs_decoder #(.NUM_BANKS(NB)) i_cs_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .addr_i      (addr),
        .atype_i     (atype),
        .rnw_i       (rnw),
        .reg_wr_i    (reg_wr),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .cs_o        (cs),
        .ps_o        (ps),
        .ack_o       (ack),
        .wp_status_o (wp_status)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req_tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [RA_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [RA_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // One request held two cycles, then released; checks both cycles and the release.
    task automatic run_req(input vec_t v);
        string t;
        logic [31:0] rd;
        t = string'(v.tag);
        @(negedge clk);
        addr = v.addr; atype = v.atype; rnw = v.rnw; req = 1'b1;
        @(negedge clk);
        check(cs == v.cs, {t, " cs first cycle"}, 32'(cs), 32'(v.cs));
        check(ps == v.ps, {t, " ps first cycle"}, 32'(ps), 32'(v.ps));
        check(ack == v.ack, {t, " ack first cycle"}, 32'(ack), 32'(v.ack));
        @(negedge clk);
        check(cs == v.cs, {t, " R6 cs held"}, 32'(cs), 32'(v.cs));
        check(ack == 1'b0, {t, " R7 ack single pulse"}, 32'(ack), 32'd0);
        req = 1'b0;
        @(negedge clk);
        check(cs == '0, {t, " R6 cs released"}, 32'(cs), 32'd0);
        exp_status = exp_status | v.viol;
        reg_read(RA_W'(8), rd);
        check(rd[3:0] == exp_status, {t, " R9 status"}, rd, 32'(exp_status));
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(cs == '0 && ack == 1'b0 && ps == '0, "R1 outputs after reset", {cs, ps, ack}, 32'd0);
        check(wp_status == '0, "R1 status after reset", 32'(wp_status), 32'd0);
        for (int k = 0; k < 2 * NB; k++) begin
            reg_read(RA_W'(k), rd);
            check(rd == 32'd0, "R1 config word reset", rd, 32'd0);
        end
        // R1: nothing programmed, so nothing matches
        run_req('{"R1 ", 32'h0000_1234, 3'd0, 1'b1, 4'b0000, 2'b00, 1'b0, 4'b0000});

        // R2: program the bank map
        reg_write(4'd0, 32'h0000_0005);
        reg_write(4'd1, 32'hFFFF_0000);
        reg_write(4'd2, 32'h0000_000B);
        reg_write(4'd3, 32'hFF00_0000);
        reg_write(4'd4, 32'h1000_0FD1);
        reg_write(4'd5, 32'hF000_0F7F);
        reg_write(4'd6, 32'h3000_0008);
        reg_write(4'd7, 32'hF000_0000);
        reg_read(4'd4, rd);
        check(rd == 32'h1000_0051, "R2 base readback reserved zero", rd, 32'h1000_0051);
        reg_read(4'd5, rd);
        check(rd == 32'hF000_0070, "R2 option readback reserved zero", rd, 32'hF000_0070);

        // Table walk
        for (int i = 0; i < $size(VECS); i++) run_req(VECS[i]);

        // R9: clear and a new violation in the same cycle; the set wins
        @(negedge clk);
        addr = 32'h0050_0000; atype = 3'd0; rnw = 1'b0; req = 1'b1;
        reg_wr = 1'b1; reg_addr = 4'd8; reg_wdata = 32'h2;
        @(negedge clk);
        reg_wr = 1'b0; req = 1'b0;
        check(wp_status == 4'b0010, "R9 set beats clear", 32'(wp_status), 32'h2);
        check(cs == '0 && ack == 1'b0, "R8 protected write no select", {cs, ack}, 32'd0);
        // R9: writing 0 keeps the bit
        reg_write(4'd8, 32'h0);
        check(wp_status == 4'b0010, "R9 write zero keeps", 32'(wp_status), 32'h2);
        // R9: writing 1 clears
        reg_write(4'd8, 32'h2);
        check(wp_status == 4'b0000, "R9 write one clears", 32'(wp_status), 32'h0);
        exp_status = '0;

        // R10: enable bank 3, now it serves its region
        reg_write(4'd6, 32'h3000_0009);
        run_req('{"R10", 32'h3000_0000, 3'd6, 1'b0, 4'b1000, 2'b10, 1'b1, 4'b0000});

        // R5: disable bank 0, so bank 1 now wins the overlap
        reg_write(4'd0, 32'h0000_0004);
        run_req('{"R5 ", 32'h0000_1234, 3'd0, 1'b1, 4'b0010, 2'b10, 1'b1, 4'b0000});

        summary();
    end
endmodule